// File: doc/BRIEF.md
# Dual-Port Same-Address Busy Arbiter

This block sits between the two access ports of a dual-port memory and its storage array. Each cycle it compares the two ports' selects and addresses. When both ports are selected and present the same address, it lets one port through, drives an active-low busy flag to the other, and stops that port's write from reaching the array. The array then sees only the winner's access to that location. Every other combination of accesses passes straight through, so each port can reach any location on its own.

The winner of a collision is set by a priority parameter. It can be a fixed left port, a fixed right port, or alternating ownership that swaps after every collision. The two busy flags are also merged into a single active-high collision indication. Logic outside the block can use that signal as an error interrupt. The decision is combinational within the access cycle. The only register is the alternation token.

Top module: `dp_collide_arb`

## Requirements
- R1: A collision exists in a cycle exactly when both chip selects are high and the two addresses are equal. `collide_any` is high in that same cycle and low in every other cycle.
- R2: During a collision exactly one of `l_busy_n`, `r_busy_n` is low (busy is active low). Outside a collision both are high.
- R3: The losing port's array write enable (`l_we_ram` or `r_we_ram`) is held low during a collision, even when that port's `we` is high. The winner's array write enable equals its own `cs & we`.
- R4: When there is no collision, each port's array write enable equals its `cs & we`, on any pair of addresses.
- R5: A port whose chip select is low never has its busy flag asserted.
- R6: `collide_any` is high exactly when at least one busy flag is low.
- R7: With `PRIO`=0 the left port wins every collision, so `r_busy_n` goes low.
- R8: With `PRIO`=1 the right port wins every collision, so `l_busy_n` goes low.
- R9: With `PRIO`=2 the winner alternates: it swaps on the clock edge that ends each collision cycle, and cycles without a collision leave it unchanged.
- R10: A collision of two reads still drives the loser's busy flag low, while both array write enables stay low.
- R11: While `rst_n` is low and after it is released, the alternation token selects the left port as the winner of the next collision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the alternation token |
| rst_n | input | 1 | Active-low synchronous reset |
| l_cs | input | 1 | Left port select |
| l_we | input | 1 | Left port write request |
| l_addr | input | AW | Left port address |
| r_cs | input | 1 | Right port select |
| r_we | input | 1 | Right port write request |
| r_addr | input | AW | Right port address |
| l_busy_n | output | 1 | Left port busy, active low |
| r_busy_n | output | 1 | Right port busy, active low |
| l_we_ram | output | 1 | Gated left write enable to the array |
| r_we_ram | output | 1 | Gated right write enable to the array |
| collide_any | output | 1 | Merged collision indication, active high |

## Verification
Three copies of the block, one per priority setting, get the same stimulus. Each result is compared with a bench model. The patterns cover:
- distinct addresses, which separate address comparison from select handling;
- equal addresses with one port deselected, which show that a select is needed before busy can fire;
- read/read, write/read and write/write collisions, which separate busy signalling from write gating.

A run of back-to-back collisions with idle cycles between them, followed by a mid-run reset, shows whether the alternating token swaps only on collisions and whether it returns to its left-first state.

// File: rtl/dp_collide_arb.sv
module dp_collide_arb #(
  parameter int AW   = 14,
  parameter int PRIO = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_cs,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic          r_cs,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  output logic          l_busy_n,
  output logic          r_busy_n,
  output logic          l_we_ram,
  output logic          r_we_ram,
  output logic          collide_any
);
  localparam int P_LEFT  = 0;
  localparam int P_RIGHT = 1;
  localparam int P_ALT   = 2;

  logic clash;
  logic right_turn;

  assign clash = l_cs & r_cs & (l_addr == r_addr);

  generate
    if (PRIO == P_ALT) begin : g_alt
      always_ff @(posedge clk) begin
        if (!rst_n)     right_turn <= 1'b0;
        else if (clash) right_turn <= ~right_turn;
      end
    end else if (PRIO == P_RIGHT) begin : g_right
      assign right_turn = 1'b1;
    end else begin : g_left
      assign right_turn = 1'b0;
    end
  endgenerate

  assign l_busy_n    = ~(clash & right_turn);
  assign r_busy_n    = ~(clash & ~right_turn);
  assign l_we_ram    = l_cs & l_we & l_busy_n;
  assign r_we_ram    = r_cs & r_we & r_busy_n;
  assign collide_any = ~l_busy_n | ~r_busy_n;

  // R2
  one_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~l_busy_n, ~r_busy_n}) <= 1);

  // R5
  desel_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !l_cs |-> l_busy_n);
  desel_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !r_cs |-> r_busy_n);

  // R3
  gate_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !l_busy_n |-> !l_we_ram);
  gate_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !r_busy_n |-> !r_we_ram);

  // R4
  apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_cs && r_cs && l_addr != r_addr) |-> (l_busy_n && r_busy_n && !collide_any));

  generate
    if (PRIO == P_ALT) begin : g_alt_chk
      // R9
      swap_to_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (collide_any && !r_busy_n) |=> (!collide_any || !l_busy_n));
      swap_to_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (collide_any && !l_busy_n) |=> (!collide_any || !r_busy_n));
    end else if (PRIO == P_RIGHT) begin : g_right_chk
      // R8
      right_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_busy_n);
    end else begin : g_left_chk
      // R7
      left_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l_busy_n);
    end
  endgenerate
endmodule

// File: tb/dp_collide_arb_test.sv
module dp_collide_arb_test;
  localparam int AW = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_cs = 0, l_we = 0, r_cs = 0, r_we = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;

  logic a_lb, a_rb, a_lw, a_rw, a_c;
  logic f_lb, f_rb, f_lw, f_rw, f_c;
  logic g_lb, g_rb, g_lw, g_rw, g_c;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit tok = 0;

  always #4 clk = ~clk;

  dp_collide_arb #(.AW(AW), .PRIO(2)) uut (
    .clk(clk), .rst_n(rst_n), .l_cs(l_cs), .l_we(l_we), .l_addr(l_addr),
    .r_cs(r_cs), .r_we(r_we), .r_addr(r_addr), .l_busy_n(a_lb), .r_busy_n(a_rb),
    .l_we_ram(a_lw), .r_we_ram(a_rw), .collide_any(a_c));

  dp_collide_arb #(.AW(AW), .PRIO(0)) uut_left (
    .clk(clk), .rst_n(rst_n), .l_cs(l_cs), .l_we(l_we), .l_addr(l_addr),
    .r_cs(r_cs), .r_we(r_we), .r_addr(r_addr), .l_busy_n(f_lb), .r_busy_n(f_rb),
    .l_we_ram(f_lw), .r_we_ram(f_rw), .collide_any(f_c));

  dp_collide_arb #(.AW(AW), .PRIO(1)) uut_right (
    .clk(clk), .rst_n(rst_n), .l_cs(l_cs), .l_we(l_we), .l_addr(l_addr),
    .r_cs(r_cs), .r_we(r_we), .r_addr(r_addr), .l_busy_n(g_lb), .r_busy_n(g_rb),
    .l_we_ram(g_lw), .r_we_ram(g_rw), .collide_any(g_c));

  task automatic check(string tag, string who, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b (lbusy_n rbusy_n lwe rwe coll)",
               tag, who, act, exp);
    end
  endtask

  function automatic logic [4:0] model(bit lwin, bit lc, bit lw, logic [AW-1:0] la,
                                       bit rc, bit rw, logic [AW-1:0] ra);
    bit coll = lc && rc && (la == ra);
    bit lb = !(coll && !lwin);
    bit rb = !(coll && lwin);
    return {lb, rb, lc & lw & lb, rc & rw & rb, coll};
  endfunction

  task automatic apply(string tag, bit lc, bit lw, logic [AW-1:0] la,
                       bit rc, bit rw, logic [AW-1:0] ra);
    @(negedge clk);
    l_cs = lc; l_we = lw; l_addr = la; r_cs = rc; r_we = rw; r_addr = ra;
    #1;
    check(tag, "alt",   {a_lb, a_rb, a_lw, a_rw, a_c}, model(!tok, lc, lw, la, rc, rw, ra));
    check(tag, "left",  {f_lb, f_rb, f_lw, f_rw, f_c}, model(1'b1, lc, lw, la, rc, rw, ra));
    check(tag, "right", {g_lb, g_rb, g_lw, g_rw, g_c}, model(1'b0, lc, lw, la, rc, rw, ra));
    @(posedge clk);
    if (lc && rc && la == ra) tok = !tok;
  endtask

  task automatic t_idle;
    apply("R4", 0, 0, 14'h0000, 0, 0, 14'h0000);
  endtask

  task automatic t_distinct;
    apply("R4", 1, 1, 14'h0010, 1, 1, 14'h0011);
    apply("R4", 1, 0, 14'h3FFE, 1, 1, 14'h3FFF);
    apply("R1", 1, 1, 14'h2000, 1, 0, 14'h0000);
  endtask

  task automatic t_deselect;
    apply("R5", 0, 1, 14'h0123, 1, 1, 14'h0123);
    apply("R5", 1, 1, 14'h0456, 0, 1, 14'h0456);
  endtask

  task automatic t_read_read;
    apply("R10", 1, 0, 14'h0777, 1, 0, 14'h0777);
  endtask

  task automatic t_write_collide;
    apply("R3", 1, 1, 14'h1234, 1, 1, 14'h1234);
    apply("R3", 1, 1, 14'h0001, 1, 0, 14'h0001);
    apply("R2", 1, 0, 14'h3FFF, 1, 1, 14'h3FFF);
  endtask

  task automatic t_alternate;
    apply("R9", 1, 1, 14'h0042, 1, 1, 14'h0042);
    apply("R9", 1, 1, 14'h0042, 1, 1, 14'h0043);
    apply("R9", 0, 0, 14'h0042, 0, 0, 14'h0042);
    apply("R9", 1, 1, 14'h0099, 1, 1, 14'h0099);
    apply("R9", 1, 1, 14'h0099, 1, 1, 14'h0099);
    apply("R6", 1, 0, 14'h0005, 1, 1, 14'h0005);
  endtask

  task automatic t_reset;
    apply("R9", 1, 1, 14'h0100, 1, 1, 14'h0100);
    @(negedge clk);
    rst_n = 0;
    @(posedge clk);
    #1;
    rst_n = 1;
    tok = 0;
    apply("R11", 1, 1, 14'h0200, 1, 1, 14'h0200);
    apply("R11", 1, 1, 14'h0200, 1, 1, 14'h0200);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    t_idle();
    t_distinct();
    t_deselect();
    t_read_read();
    t_write_collide();
    t_alternate();
    t_reset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule